// File: doc/BRIEF.md
# Vector Element Index Remapper

This block turns a linear vector element number into a reshaped register offset. A vector can then be read as a 2D or 3D array whose axes are walked in a chosen order. Three shape words sit in a small bank. Each word holds three axis extents, written as size minus one, and a 3-bit axis-order code. A shape word that is all zero means no reshaping, so the offset is simply the linear element number.

There are two independent channels, one for each operand offset of a twin-operand operation. A channel is started by a load. The load captures a shape word, or the bypass setting, and a starting element number, which may be a number saved when an element loop was interrupted. The channel then rebuilds its axis counters by stepping from zero, one step per cycle, and holds `busy_o` high while it does so. After that, each cycle with the advance strobe high moves the channel forward by one element. The axis counters wrap at their extents. A shape whose total size is below the maximum vector length therefore presents the same offsets again.

Top module: `vidx_remap`

## Requirements
- R1: A write with `cfg_we_i` high and `cfg_sel_i` equal to 0, 1 or 2 stores `cfg_data_i` into that shape word, and the stored word takes effect at the next load. A write with `cfg_sel_i` equal to 3 changes no shape word. Shape word layout: x size-1 in bits [6:0], y size-1 in bits [13:7], z size-1 in bits [20:14], order code in bits [23:21], bits [31:24] reserved.
- R2: A channel loaded with select value 3 (bypass), or with a shape word that is entirely zero, outputs the linear element number. Each advance increments that number by 1, modulo 128.
- R3: With extents X, Y and Z, the offset is x + y·X + z·X·Y modulo 128, where x, y and z are the current axis counters.
- R4: The order code sets which axis steps fastest, second and slowest. 000 gives (x,y,z), 001 gives (y,x,z), 010 gives (x,z,y), 011 gives (z,x,y), 100 gives (y,z,x) and 101 gives (z,y,x). When two extents are 1, the walk matches the natural order whatever the code.
- R5: Order codes 110 and 111 behave exactly like 000.
- R6: Each axis counter wraps to zero at its extent and carries into the next axis in the chosen order. The slowest axis wraps to zero, so offsets repeat after X·Y·Z elements.
- R7: A load with start value n holds `busy_o` high for exactly n cycles and `valid_o` equals the inverse of `busy_o`. After the load, the offset equals the offset reached by n advances from element 0.
- R8: Advance strobes have no effect while a channel is busy. A load in the same cycle as an advance takes priority, and the advance is dropped.
- R9: The two channels keep separate shape selections, element numbers and strobes, and neither affects the other.
- R10: After reset, every channel outputs offset 0 in linear mode, with `busy_o` low and `valid_o` high.
- R11: A channel keeps the shape captured at its load. A later write to that shape word does not change the channel's offsets until the channel is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Shape word write strobe |
| cfg_sel_i | input | 2 | Shape word index for a write |
| cfg_data_i | input | 32 | Shape word write data |
| ld_i | input | 2 | Per-channel load strobe |
| ld_sel_i | input | 4 | Per-channel shape select, 2 bits each; 3 means bypass |
| ld_idx_i | input | 14 | Per-channel start element number, 7 bits each |
| adv_i | input | 2 | Per-channel advance strobe |
| busy_o | output | 2 | Per-channel counter rebuild in progress |
| valid_o | output | 2 | Per-channel offset valid |
| offset_o | output | 14 | Per-channel remapped offset, 7 bits each |

## Verification
The bench uses the default parameters: two channels, three shape words and 7-bit indices, which gives a maximum vector length of 128. With these values, a 3×2×2 shape walked under every order code gives short sequences that can be checked by hand. A 4×4×8 shape fills all 128 elements and reaches the top offset. A 5×1×1 shape covers the case of two unit extents. Start values up to 100 exercise rebuilds of up to a hundred cycles. Because there are two channels, independence can be checked by running both at once with different shapes and different busy lengths.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int SHAPE_W = 32;
  localparam int DIM_W   = 7;
  localparam int AXES    = 3;

  typedef struct packed {
    logic [7:0]       rsvd;
    logic [2:0]       order;
    logic [DIM_W-1:0] z_sz;
    logic [DIM_W-1:0] y_sz;
    logic [DIM_W-1:0] x_sz;
  } shape_t;

  // packed {slowest, middle, fastest}; axis 0=x 1=y 2=z
  function automatic logic [5:0] axis_order(input logic [2:0] code);
    case (code)
      3'b001:  axis_order = {2'd2, 2'd0, 2'd1};
      3'b010:  axis_order = {2'd1, 2'd2, 2'd0};
      3'b011:  axis_order = {2'd1, 2'd0, 2'd2};
      3'b100:  axis_order = {2'd0, 2'd2, 2'd1};
      3'b101:  axis_order = {2'd0, 2'd1, 2'd2};
      default: axis_order = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/remap_shape_bank.sv
module remap_shape_bank
  import remap_pkg::*;
#(
  parameter int NUM_SHAPES = 3,
  parameter int SEL_W      = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [SHAPE_W-1:0]            data_i,
  output logic [NUM_SHAPES*SHAPE_W-1:0] words_o
);
  logic [SHAPE_W-1:0] word_q [NUM_SHAPES];

  for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[s] <= '0;
      end else if (we_i && int'(sel_i) == s) begin
        word_q[s] <= data_i;
      end
    end
    assign words_o[s*SHAPE_W +: SHAPE_W] = word_q[s];
  end

  AST_CFG_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && int'(sel_i) < NUM_SHAPES |=>
      words_o[$past(sel_i)*SHAPE_W +: SHAPE_W] == $past(data_i)); // R1
endmodule

// File: rtl/remap_chan.sv
module remap_chan
  import remap_pkg::*;
#(
  parameter int IDX_W = DIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  shape_t           ld_shape_i,
  input  logic             adv_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] offset_o
);
  shape_t           shape_q;
  logic [IDX_W-1:0] cnt_q [AXES];
  logic [IDX_W-1:0] cnt_d [AXES];
  logic [IDX_W-1:0] lim   [AXES];
  logic [IDX_W-1:0] lin_q, rem_q;
  logic             busy_q;
  logic             linear;
  logic [5:0]       ord;
  logic [IDX_W-1:0] ext_x, ext_y;

  assign linear = (shape_q == '0);
  assign ord    = axis_order(shape_q.order);
  assign lim[0] = IDX_W'(shape_q.x_sz);
  assign lim[1] = IDX_W'(shape_q.y_sz);
  assign lim[2] = IDX_W'(shape_q.z_sz);

  // one element step, fastest axis first, carry ripples outward
  always_comb begin
    logic       carry;
    logic [1:0] a;
    carry = 1'b1;
    for (int k = 0; k < AXES; k++) cnt_d[k] = cnt_q[k];
    for (int k = 0; k < AXES; k++) begin
      a = ord[2*k +: 2];
      if (carry) begin
        if (cnt_q[a] == lim[a]) begin
          cnt_d[a] = '0;
        end else begin
          cnt_d[a] = cnt_q[a] + IDX_W'(1);
          carry    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shape_q <= '0;
      lin_q   <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      for (int k = 0; k < AXES; k++) cnt_q[k] <= '0;
    end else if (ld_i) begin
      shape_q <= ld_shape_i;
      lin_q   <= ld_idx_i;
      rem_q   <= ld_idx_i;
      busy_q  <= (ld_idx_i != '0);
      for (int k = 0; k < AXES; k++) cnt_q[k] <= '0;
    end else if (busy_q) begin
      rem_q  <= rem_q - IDX_W'(1);
      busy_q <= (rem_q != IDX_W'(1));
      for (int k = 0; k < AXES; k++) cnt_q[k] <= cnt_d[k];
    end else if (adv_i) begin
      lin_q <= lin_q + IDX_W'(1);
      for (int k = 0; k < AXES; k++) cnt_q[k] <= cnt_d[k];
    end
  end

  // modulo-2^IDX_W arithmetic matches the truncated offset
  assign ext_x    = lim[0] + IDX_W'(1);
  assign ext_y    = lim[1] + IDX_W'(1);
  assign offset_o = linear ? lin_q
                  : IDX_W'(cnt_q[0] + cnt_q[1] * ext_x + cnt_q[2] * ext_x * ext_y);
  assign busy_o   = busy_q;
  assign valid_o  = !busy_q;

  AST_LOAD_ZERO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && ld_idx_i == '0 |=> !busy_o && offset_o == '0); // R7
  AST_LOAD_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && ld_idx_i != '0 |=> busy_o); // R7
  AST_BUSY_IGNORES_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ld_i |=> lin_q == $past(lin_q)); // R8
  AST_LOAD_BEATS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && adv_i |=> lin_q == $past(ld_idx_i)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !adv_i && !ld_i |=> $stable(offset_o)); // R11
  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && adv_i && !ld_i && linear |=> offset_o == $past(offset_o) + IDX_W'(1)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[0] <= lim[0] && cnt_q[1] <= lim[1] && cnt_q[2] <= lim[2]); // R6
endmodule

// File: rtl/vidx_remap.sv
module vidx_remap
  import remap_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int NUM_SHAPES = 3,
  parameter int IDX_W      = DIM_W,
  localparam int SEL_W     = $clog2(NUM_SHAPES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [SEL_W-1:0]       cfg_sel_i,
  input  logic [SHAPE_W-1:0]     cfg_data_i,
  input  logic [NCH-1:0]         ld_i,
  input  logic [NCH*SEL_W-1:0]   ld_sel_i,
  input  logic [NCH*IDX_W-1:0]   ld_idx_i,
  input  logic [NCH-1:0]         adv_i,
  output logic [NCH-1:0]         busy_o,
  output logic [NCH-1:0]         valid_o,
  output logic [NCH*IDX_W-1:0]   offset_o
);
  logic [NUM_SHAPES*SHAPE_W-1:0] words;

  remap_shape_bank #(
    .NUM_SHAPES(NUM_SHAPES),
    .SEL_W     (SEL_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .words_o(words)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    shape_t           shp;

    assign sel = ld_sel_i[c*SEL_W +: SEL_W];
    // select values past the bank pick bypass (all-zero shape)
    always_comb begin
      shp = '0;
      for (int s = 0; s < NUM_SHAPES; s++) begin
        if (int'(sel) == s) shp = words[s*SHAPE_W +: SHAPE_W];
      end
    end

    remap_chan #(.IDX_W(IDX_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (ld_i[c]),
      .ld_idx_i  (ld_idx_i[c*IDX_W +: IDX_W]),
      .ld_shape_i(shp),
      .adv_i     (adv_i[c]),
      .busy_o    (busy_o[c]),
      .valid_o   (valid_o[c]),
      .offset_o  (offset_o[c*IDX_W +: IDX_W])
    );
  end
endmodule

// File: tb/tb_vidx_remap.sv
module tb_vidx_remap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic [1:0]  ld = '0;
  logic [3:0]  ld_sel = '0;
  logic [13:0] ld_idx = '0;
  logic [1:0]  adv = '0;
  logic [1:0]  busy, valid;
  logic [13:0] offset;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidx_remap dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .ld_i(ld), .ld_sel_i(ld_sel), .ld_idx_i(ld_idx),
    .adv_i(adv), .busy_o(busy), .valid_o(valid), .offset_o(offset)
  );

  function automatic logic [31:0] mk(int xs, int ys, int zs, int code);
    mk = {8'h00, 3'(code), 7'(zs), 7'(ys), 7'(xs)};
  endfunction

  typedef struct packed {
    logic [31:0] shp;
    logic [6:0]  start;
    logic [7:0]  nadv;
    logic [6:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // 3x2x2 shape under several orders, plus a few other shapes
  localparam vec_t VEC [NV] = '{
    '{mk(2,1,1,0),   7'd5,   8'd0,   7'd5,   4'd3},
    '{mk(2,1,1,0),   7'd0,   8'd13,  7'd1,   4'd6},
    '{mk(2,1,1,1),   7'd7,   8'd0,   7'd9,   4'd4},
    '{mk(2,1,1,1),   7'd3,   8'd4,   7'd9,   4'd7},
    '{mk(2,1,1,1),   7'd2,   8'd0,   7'd1,   4'd4},
    '{mk(2,1,1,3),   7'd3,   8'd0,   7'd7,   4'd4},
    '{mk(2,1,1,3),   7'd1,   8'd6,   7'd9,   4'd4},
    '{mk(2,1,1,5),   7'd3,   8'd0,   7'd9,   4'd4},
    '{mk(2,1,1,5),   7'd0,   8'd4,   7'd1,   4'd4},
    '{mk(2,1,1,6),   7'd5,   8'd0,   7'd5,   4'd5},
    '{mk(2,1,1,7),   7'd13,  8'd0,   7'd1,   4'd5},
    '{mk(4,0,0,5),   7'd7,   8'd0,   7'd2,   4'd4},
    '{32'h0,         7'd100, 8'd30,  7'd2,   4'd2},
    '{mk(3,3,7,2),   7'd37,  8'd0,   7'd21,  4'd3},
    '{mk(3,3,7,2),   7'd0,   8'd127, 7'd127, 4'd3}
  };

  function automatic string rname(logic [3:0] r);
    case (r)
      4'd2: rname = "R2";
      4'd3: rname = "R3";
      4'd4: rname = "R4";
      4'd5: rname = "R5";
      4'd6: rname = "R6";
      default: rname = "R7";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(int s, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // load one channel, return number of busy cycles seen
  task automatic load(int c, int s, int idx, output int nbusy);
    ld[c] = 1'b1; ld_sel[c*2 +: 2] = 2'(s); ld_idx[c*7 +: 7] = 7'(idx);
    @(negedge clk);
    ld[c] = 1'b0;
    nbusy = 0;
    while (busy[c] && nbusy < 300) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic advance(int c, int n);
    for (int i = 0; i < n; i++) begin
      adv[c] = 1'b1;
      @(negedge clk);
    end
    adv[c] = 1'b0;
  endtask

  function automatic int off(int c);
    off = int'(offset[c*7 +: 7]);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nb, nb1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10", "ch0 offset", off(0), 0);
    check("R10", "ch1 offset", off(1), 0);
    check("R10", "busy", int'(busy), 0);
    check("R10", "valid", int'(valid), 3);

    // table walk on channel 0, shape word 0
    for (int v = 0; v < NV; v++) begin
      cfg_write(0, VEC[v].shp);
      load(0, 0, int'(VEC[v].start), nb);
      check("R7", "busy cycles", nb, int'(VEC[v].start));
      check("R7", "valid after load", int'(valid[0]), 1);
      advance(0, int'(VEC[v].nadv));
      check(rname(VEC[v].req), $sformatf("vector %0d offset", v), off(0), int'(VEC[v].exp));
    end

    // R8: advance held through busy is dropped; load wins over advance
    adv[0] = 1'b1;
    load(0, 3, 20, nb);
    adv[0] = 1'b0;
    check("R8", "offset after busy with adv", off(0), 20);
    adv[0] = 1'b1;
    load(0, 3, 0, nb);
    adv[0] = 1'b0;
    check("R8", "load priority over adv", off(0), 0);

    // R11: captured shape survives a rewrite of its word
    cfg_write(1, mk(2,1,1,0));
    load(1, 1, 0, nb);
    advance(1, 4);
    check("R11", "before rewrite", off(1), 4);
    cfg_write(1, mk(2,1,1,1));
    advance(1, 1);
    check("R11", "after rewrite, old shape", off(1), 5);
    load(1, 1, 1, nb);
    check("R11", "after reload, new shape", off(1), 3);

    // R9: both channels at once, different shapes and start values
    cfg_write(2, mk(4,0,0,0));
    ld = 2'b11; ld_sel = {2'd3, 2'd2}; ld_idx = {7'd9, 7'd6};
    @(negedge clk);
    ld = 2'b00;
    nb = 0; nb1 = 0;
    while (busy != 2'b00 && nb < 300) begin
      if (busy[0]) nb++;
      if (busy[1]) nb1++;
      @(negedge clk);
    end
    check("R9", "ch0 busy cycles", nb, 6);
    check("R9", "ch1 busy cycles", nb1, 9);
    adv = 2'b11;
    repeat (3) @(negedge clk);
    adv = 2'b00;
    check("R9", "ch0 offset", off(0), 4);
    check("R9", "ch1 offset", off(1), 12);
    advance(1, 2);
    check("R9", "ch1 after own advance", off(1), 14);
    check("R9", "ch0 untouched", off(0), 4);

    // R1: select 3 writes nothing; word 2 still holds the 5x1x1 shape
    cfg_write(3, mk(1,1,1,0));
    load(0, 2, 9, nb);
    check("R1", "word 2 intact", off(0), 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule